// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is a single DMA channel that moves data between a device and a series of memory buffers. The buffers are listed in a descriptor table in system memory. Software loads the table address, issues a start command, and then clears the channel mask. The channel reads each descriptor over a 32-bit memory read port and places it in a reserve (base) buffer set. On each device request it transfers one unit from the active (current) buffer set.

The current set always draws from the base set. While the current buffer is being transferred, the channel fetches the next descriptor into the empty base set. It does this only in cycles in which no data transfer takes place. When the current buffer runs out and the base set is already loaded, the next buffer starts on the following transfer with no idle cycle. After the channel reads a descriptor flagged as the last one, it stops fetching and finishes the buffers it holds. It then reports completion, either as a one-cycle pulse or as a held interrupt, and masks itself.

Top module: `sg_dma_chan`

## Requirements
- R1: A descriptor is two 32-bit words. The word at the table pointer is the buffer start address. The word at pointer+4 holds the byte count in bits 23:0 and the last-descriptor flag in bit 31; bits 30:24 must be zero. The pointer is written through register select 0 with bits 1:0 forced to zero, and it advances by 8 after each descriptor is fetched.
- R2: A write to register select 1 with bit 0 set is a start command. It sets the active status, clears the terminate status and clears the interrupt. While the mask (register select 2, bit 0) is set, the channel makes no memory read and no device transfer.
- R3: Once the channel is active and unmasked, it fetches the first descriptor into the base set without any device request.
- R4: A transfer made while the current set is empty takes the base set's address and count, which leaves the base set empty. Whenever the base set is empty and the last descriptor has not been read, a new fetch is requested.
- R5: The memory read request is never asserted in a cycle in which a device transfer is acknowledged.
- R6: With a buffer loaded and the channel running, a device request is acknowledged in the same cycle. Each transfer drives the next unit address (start + k×4) and lowers the count by 4. A buffer ends when its count reaches zero.
- R7: If the base set is loaded when the current buffer ends, the next buffer's first unit is transferred in the very next cycle. If the base set is empty, transfers stall until the fetch completes.
- R8: Once the last descriptor has been read, no further memory reads occur, and every unit of the buffers already held is still transferred.
- R9: After the final unit, the terminate status is set, active is cleared and the mask is set. If command bit 1 was 0, completion is a one-cycle done pulse. If it was 1, the interrupt output rises and stays high until the next start.
- R10: After reset the mask is set, the active and terminate status bits are clear, and there are no requests, acknowledges or completion signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 command, 2 mask |
| cfg_wdata | input | 32 | Register write data |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_ack | input | 1 | Read accepted; data valid this cycle |
| mem_rd_data | input | 32 | Descriptor word read data |
| dev_req | input | 1 | Device transfer request |
| dev_ack | output | 1 | Transfer performed this cycle |
| xfer_addr | output | 32 | Memory address of the unit being transferred |
| done_pulse | output | 1 | One-cycle completion pulse (pulse mode) |
| irq_o | output | 1 | Completion interrupt, held until next start (interrupt mode) |
| stat_active | output | 1 | Active status |
| stat_term | output | 1 | Terminate status |
| chan_mask | output | 1 | Channel mask |

## Verification
The lists are run under random device request density and random memory acknowledge density. A sparse request pattern gives the prefetch room to run ahead, while a dense one makes it yield and shows whether the fetch really gives way to transfers. A directed pattern holds requests off until the reserve set has filled, then requests back to back. It separates the seamless buffer handover from the stall that a continuously requested list produces. A delayed unmask and a list whose last flag is followed by a further descriptor in memory check that nothing starts early and that nothing is read past the end. Both completion modes are run.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 24;
    localparam int LAST_BIT   = 31;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_BYTES = 2 * WORD_BYTES;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              last;
    } desc_t;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } bufset_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_LO,
        F_HI
    } fphase_e;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_MASK = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/sg_desc_fetch.sv
module sg_desc_fetch
    import sg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              want,
    input  logic              grant,
    input  logic [ADDR_W-1:0] tbl_ptr,
    input  logic              mem_rd_ack,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              desc_valid,
    output desc_t             desc
);
    typedef struct packed {
        fphase_e           phase;
        logic [ADDR_W-1:0] lo;
    } fstate_t;

    fstate_t q, d;
    logic    beat;

    always_comb begin
        d           = q;
        desc_valid  = 1'b0;
        mem_rd_req  = (q.phase != F_IDLE) && grant;
        mem_rd_addr = tbl_ptr + ((q.phase == F_HI) ? ADDR_W'(WORD_BYTES) : '0);
        beat        = mem_rd_req && mem_rd_ack;
        desc.addr   = q.lo;
        desc.cnt    = mem_rd_data[CNT_W-1:0];
        desc.last   = mem_rd_data[LAST_BIT];
        if (clear) begin
            d.phase = F_IDLE;
        end else begin
            unique case (q.phase)
                F_IDLE: if (want) d.phase = F_LO;
                F_LO: if (beat) begin
                    d.lo    = mem_rd_data[ADDR_W-1:0];
                    d.phase = F_HI;
                end
                F_HI: if (beat) begin
                    desc_valid = 1'b1;
                    d.phase    = F_IDLE;
                end
                default: d.phase = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: F_IDLE, lo: '0};
        else        q <= d;
    end

    // R1: descriptor words are word aligned
    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

    // R1: reserved count-word bits must be zero when the count word is taken
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (mem_rd_data[LAST_BIT-1:CNT_W] == '0));
endmodule

// File: rtl/sg_buf_sets.sv
module sg_buf_sets
    import sg_dma_pkg::*;
#(
    parameter int UNIT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              dev_req,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic              dev_ack,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              base_v,
    output logic              last_done
);
    localparam logic [CNT_W-1:0]  UNIT_C = CNT_W'(UNIT_BYTES);
    localparam logic [ADDR_W-1:0] UNIT_A = ADDR_W'(UNIT_BYTES);

    typedef struct packed {
        bufset_t cur;
        bufset_t base;
    } sets_t;

    sets_t   q, d;
    bufset_t src;
    logic    hit_zero;

    always_comb begin
        d         = q;
        src       = q.cur.v ? q.cur : q.base;
        dev_ack   = run && dev_req && (q.cur.v || q.base.v);
        xfer_addr = src.addr;
        hit_zero  = (src.cnt <= UNIT_C);
        last_done = dev_ack && hit_zero && !(q.cur.v && q.base.v);
        base_v    = q.base.v;
        if (clear) begin
            d.cur.v  = 1'b0;
            d.base.v = 1'b0;
        end else begin
            if (dev_ack) begin
                if (!q.cur.v) d.base.v = 1'b0;
                d.cur.v    = !hit_zero;
                d.cur.addr = src.addr + UNIT_A;
                d.cur.cnt  = src.cnt - UNIT_C;
            end
            if (load) begin
                d.base.v    = 1'b1;
                d.base.addr = load_addr;
                d.base.cnt  = load_cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: a transfer out of an empty current set consumes the base set
    assert_base_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && !q.cur.v && !clear) |=> !q.base.v);

    // R4: a fetched descriptor only lands in an empty base set
    assert_load_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !q.base.v);

    // R6: within a buffer the address steps by one unit per transfer
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && q.cur.v && !hit_zero && !clear) |=>
            (q.cur.addr == $past(q.cur.addr) + UNIT_A));
endmodule

// File: rtl/sg_dma_chan.sv
module sg_dma_chan
    import sg_dma_pkg::*;
#(
    parameter int UNIT_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ack,
    input  logic [31:0] mem_rd_data,
    input  logic        dev_req,
    output logic        dev_ack,
    output logic [31:0] xfer_addr,
    output logic        done_pulse,
    output logic        irq_o,
    output logic        stat_active,
    output logic        stat_term,
    output logic        chan_mask
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              irq_mode;
        logic              active;
        logic              term;
        logic              mask;
        logic              irq;
        logic              last_seen;
        logic              done;
    } ctl_t;

    ctl_t  q, d;
    logic  run, want, grant, start;
    logic  desc_valid, base_v, last_done;
    desc_t desc;

    assign run   = q.active && !q.mask;
    assign want  = run && !base_v && !q.last_seen;
    assign grant = run && !dev_ack;
    assign start = cfg_we && (cfg_sel == SEL_CMD) && cfg_wdata[0];

    sg_desc_fetch u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start),
        .want        (want),
        .grant       (grant),
        .tbl_ptr     (q.ptr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .desc_valid  (desc_valid),
        .desc        (desc)
    );

    sg_buf_sets #(.UNIT_BYTES(UNIT_BYTES)) u_sets (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .run       (run),
        .dev_req   (dev_req),
        .load      (desc_valid),
        .load_addr (desc.addr),
        .load_cnt  (desc.cnt),
        .dev_ack   (dev_ack),
        .xfer_addr (xfer_addr),
        .base_v    (base_v),
        .last_done (last_done)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_PTR:  d.ptr = {cfg_wdata[ADDR_W-1:2], 2'b00};
                SEL_CMD: begin
                    d.irq_mode = cfg_wdata[1];
                    if (cfg_wdata[0]) begin
                        d.active    = 1'b1;
                        d.term      = 1'b0;
                        d.irq       = 1'b0;
                        d.last_seen = 1'b0;
                    end
                end
                SEL_MASK: d.mask = cfg_wdata[0];
                default: ;
            endcase
        end
        if (desc_valid) begin
            d.ptr = q.ptr + ADDR_W'(DESC_BYTES);
            if (desc.last) d.last_seen = 1'b1;
        end
        if (last_done && q.last_seen) begin
            d.active = 1'b0;
            d.term   = 1'b1;
            d.mask   = 1'b1;
            if (q.irq_mode) d.irq  = 1'b1;
            else            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_pulse  = q.done;
    assign irq_o       = q.irq;
    assign stat_active = q.active;
    assign stat_term   = q.term;
    assign chan_mask   = q.mask;

    // R5: a pending fetch gives way to a data transfer
    assert_fetch_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !dev_ack);

    // R2: a masked channel is silent
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chan_mask |-> (!dev_ack && !mem_rd_req));

    // R8: nothing is read once the final descriptor is held
    assert_no_read_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.last_seen |-> !mem_rd_req);

    // R9: the done pulse comes with the finished status and lasts one cycle
    assert_done_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (chan_mask && stat_term && !stat_active));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
endmodule

// File: tb/sim_sg_dma_chan.sv
module sim_sg_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_rd_req, mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic        dev_req = 1'b0, dev_ack;
    logic [31:0] xfer_addr;
    logic        done_pulse, irq_o, stat_active, stat_term, chan_mask;

    always #5 clk = ~clk;

    sg_dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .dev_req(dev_req),
        .dev_ack(dev_ack), .xfer_addr(xfer_addr), .done_pulse(done_pulse),
        .irq_o(irq_o), .stat_active(stat_active), .stat_term(stat_term),
        .chan_mask(chan_mask)
    );

    logic [31:0] memw [64];
    assign mem_rd_data = memw[mem_rd_addr[7:2]];

    localparam logic [31:0] TBL = 32'h0000_0040;
    logic [31:0] exp_xa [64];
    int ack_cyc [64];
    int n_exp, idx, fetch_idx, eop_cnt, cyc;
    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    function automatic bit roll(input int pct);
        return int'($urandom % 100) < pct;
    endfunction

    // one clock: drive away from the edge, then record what the edge will do
    task automatic step(input int rq, input int ak);
        @(negedge clk);
        dev_req = roll(rq);
        #1;
        mem_rd_ack = mem_rd_req && roll(ak);
        #1;
        if (dev_ack) begin
            if (idx < n_exp) chk(xfer_addr == exp_xa[idx], "R6 unit address", xfer_addr, exp_xa[idx]);
            else             chk(1'b0, "R8 transfer beyond list", xfer_addr, '0);
            chk(!mem_rd_req, "R5 fetch while transfer", 32'(mem_rd_req), 0);
            if (idx < 64) ack_cyc[idx] = cyc;
            idx++;
        end
        if (mem_rd_req && mem_rd_ack) begin
            chk(mem_rd_addr == TBL + 32'(4 * fetch_idx), "R1 fetch address", mem_rd_addr, TBL + 32'(4 * fetch_idx));
            fetch_idx++;
        end
        if (done_pulse) eop_cnt++;
        cyc++;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        dev_req = 1'b0; mem_rd_ack = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    // builds n listed descriptors plus one trailing descriptor that must never be read
    task automatic build(input int n, input int fixed_len);
        int base_w = int'(TBL[7:2]);
        n_exp = 0; idx = 0; fetch_idx = 0; eop_cnt = 0;
        for (int i = 0; i <= n; i++) begin
            logic [31:0] a = 32'h1000_0000 + 32'(i << 12) + 32'(($urandom % 64) * 4);
            int len = (fixed_len > 0) ? fixed_len : 1 + int'($urandom % 5);
            memw[base_w + 2 * i]     = a;
            memw[base_w + 2 * i + 1] = {(i == n - 1), 7'd0, 24'(len * 4)};
            if (i < n) for (int k = 0; k < len; k++) begin
                exp_xa[n_exp] = a + 32'(4 * k);
                n_exp++;
            end
        end
    endtask

    task automatic start_list(input bit mode);
        cfg(2'd0, TBL | 32'h3);
        cfg(2'd1, {30'd0, mode, 1'b1});
        chk(stat_active, "R2 active after start", 32'(stat_active), 1);
        chk(!stat_term && !irq_o, "R2 term/irq cleared by start", {stat_term, irq_o}, 0);
    endtask

    task automatic finish_checks(input int n, input bit mode);
        repeat (6) step(100, 100);
        chk(idx == n_exp, "R8 all held units transferred", 32'(idx), 32'(n_exp));
        chk(fetch_idx == 2 * n, "R8 no read past last", 32'(fetch_idx), 32'(2 * n));
        chk(stat_term && !stat_active && chan_mask, "R9 final status",
            {stat_term, stat_active, chan_mask}, 3'b101);
        chk(eop_cnt == (mode ? 0 : 1), "R9 done pulse count", 32'(eop_cnt), mode ? 0 : 1);
        chk(irq_o == mode, "R9 interrupt level", 32'(irq_o), 32'(mode));
    endtask

    task automatic run_list(input int n, input bit mode, input int rq, input int ak, input int hold);
        build(n, 0);
        start_list(mode);
        if (hold > 0) begin
            repeat (hold) step(100, 100);
            chk(idx == 0 && fetch_idx == 0, "R2 masked channel idle", 32'(idx + fetch_idx), 0);
        end
        cfg(2'd2, 32'd0);
        for (int k = 0; k < 4000 && !stat_term; k++) step(rq, ak);
        finish_checks(n, mode);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) memw[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state, with a device request present
        @(negedge clk);
        dev_req = 1'b1;
        #1;
        chk(chan_mask && !stat_active && !stat_term, "R10 reset status",
            {chan_mask, stat_active, stat_term}, 3'b100);
        chk(!mem_rd_req && !dev_ack && !done_pulse && !irq_o, "R10 reset outputs",
            {mem_rd_req, dev_ack, done_pulse, irq_o}, 0);

        // R2 delayed unmask, pulse mode
        run_list(3, 1'b0, 60, 70, 12);

        // R9 interrupt mode: held until the next start
        run_list(2, 1'b1, 50, 50, 0);
        repeat (5) step(0, 100);
        chk(irq_o, "R9 interrupt held", 32'(irq_o), 1);

        // R3 / R4 / R7 seamless handover after the reserve has filled
        build(2, 2);
        start_list(1'b0);
        cfg(2'd2, 32'd0);
        repeat (6) step(0, 100);
        chk(fetch_idx == 2 && idx == 0, "R3 first descriptor fetched unprompted", 32'(fetch_idx), 2);
        step(100, 100);
        repeat (6) step(0, 100);
        chk(fetch_idx == 4, "R4 reserve refetched", 32'(fetch_idx), 4);
        for (int k = 0; k < 100 && !stat_term; k++) step(100, 100);
        chk(ack_cyc[2] == ack_cyc[1] + 1, "R7 no idle cycle at handover", 32'(ack_cyc[2] - ack_cyc[1]), 1);
        finish_checks(2, 1'b0);

        // R7 stall: continuous requests leave no room for the prefetch
        build(2, 2);
        start_list(1'b0);
        cfg(2'd2, 32'd0);
        for (int k = 0; k < 100 && !stat_term; k++) step(100, 100);
        chk(ack_cyc[2] > ack_cyc[1] + 1, "R7 stall while reserve empty", 32'(ack_cyc[2] - ack_cyc[1]), 2);
        finish_checks(2, 1'b0);

        // random lists, densities and modes
        for (int r = 0; r < 8; r++)
            run_list(1 + int'($urandom % 4), bit'($urandom % 2),
                     10 + int'($urandom % 91), 20 + int'($urandom % 81), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule